// File: doc/BRIEF.md
# Gated Bit-Serial Receive FIFO

This block buffers single demodulated data bits on their way to an external controller. Each incoming bit arrives with a valid strobe. It is stored only after a qualification gate has armed. The gate arms on a valid-data indicator, on a sync-word match, on either of them or on both together, as configuration selects. Bits that arrive before the gate arms are thrown away, so line noise never occupies the buffer. The gate stays armed until the fill enable is dropped. Dropping the fill enable also empties the buffer.

The controller drains the buffer one bit at a time. While it holds the active-low select, every falling edge of its serial clock moves the oldest stored bit onto the serial output. A programmable level drives a fill flag that can serve as an interrupt. With the level at 1, the flag can also be polled as a "bits still waiting" indicator. Two sticky status bits record why attention is needed: a threshold crossing and a dropped write.

The serial clock and the select are brought into the reference clock domain by synchronizers. For this reason the serial clock must run at no more than a quarter of the reference clock, and each of its phases must last at least two reference periods.

Top module: `gated_bit_fifo`

## Requirements
- R1: After reset, fill_flag, sdo, stat_thr and stat_ovf are all 0 and the buffer is empty.
- R2: The buffer holds up to DEPTH (default 64) bits. The stored count never goes above DEPTH.
- R3: A strobed bit (din_vld=1) is stored only when fill_en=1 and either the gate is already armed or the qualifier selected by arm_sel is true in that same cycle. The encodings are 0 = valid-data indicator (vdi), 1 = sync match (sync_hit), 2 = either of them, 3 = both together. Any other strobed bit is discarded.
- R4: Once armed, the gate stays armed for as long as fill_en stays 1, even after the qualifier signals go low.
- R5: fill_flag is 1 exactly when the stored count is nonzero and at least `level`. With level 1 the flag is high while any bit is stored.
- R6: While fsel_n is low, each falling edge of sclk removes the oldest stored bit and drives it on sdo. sdo changes three reference clock edges after sclk goes low. sdo holds between reads.
- R7: A falling edge of sclk while fsel_n is high has no effect on the stored bits or on sdo.
- R8: A read while the buffer is empty drives sdo to 0 and leaves the count unchanged.
- R9: A strobed, qualified bit that arrives while DEPTH bits are stored, with no read in the same cycle, is dropped and sets stat_ovf. stat_ovf stays set until stat_rd is pulsed. A new overflow in that same cycle wins over the clear.
- R10: One cycle after fill_flag rises, stat_thr is set. It stays set until stat_rd clears it, and a new rise in the same cycle wins over the clear.
- R11: fill_en=0 empties the buffer and disarms the gate, so the next packet must qualify again.
- R12: A write and a read in the same cycle leave the count unchanged and keep the bits in order. At full, the read frees room so that the write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| din | input | 1 | Demodulated data bit |
| din_vld | input | 1 | Strobe marking din as a new bit |
| vdi | input | 1 | Valid-data indicator |
| sync_hit | input | 1 | Sync-word match indicator |
| fill_en | input | 1 | Fill enable; low clears the buffer and disarms the gate |
| arm_sel | input | 2 | Qualification mode: 0 vdi, 1 sync, 2 either, 3 both |
| level | input | PTR_W (6) | Fill flag threshold |
| sclk | input | 1 | Serial read clock from the controller |
| fsel_n | input | 1 | Active-low FIFO read select |
| stat_rd | input | 1 | Status read pulse; clears the sticky status bits |
| sdo | output | 1 | Serial data out |
| fill_flag | output | 1 | Threshold / bits-available flag |
| stat_thr | output | 1 | Sticky threshold-crossed status |
| stat_ovf | output | 1 | Sticky overflow status |

## Verification
A synchronized serial read can land on the same reference edge as a strobed incoming bit. This is the case where the count, the pointers and the full test interact. The bench provokes it by raising din_vld for exactly the cycle in which the delayed sclk fall pops a bit. It does this with a partly filled buffer and again with a full one. A behavioural queue model predicts the flag, sdo and both status bits, and the bench compares them every cycle. A wrong count or a lost bit therefore shows up as a flag mismatch or a wrong bit later in the drain.

// File: rtl/gbf_pkg.sv
package gbf_pkg;
  typedef enum logic [1:0] {
    ARM_VALID  = 2'b00,
    ARM_SYNC   = 2'b01,
    ARM_EITHER = 2'b10,
    ARM_BOTH   = 2'b11
  } arm_mode_e;
endpackage

// File: rtl/gbf_sync.sv
module gbf_sync #(
  parameter int STAGES = 2,
  parameter bit IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic fall
);
  logic [STAGES:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {(STAGES+1){IDLE}};
    else        sh_q <= sh_d;
  end

  assign q    = sh_q[STAGES-1];
  assign fall = sh_q[STAGES] & ~sh_q[STAGES-1];

  // R6: one detected edge per sclk fall
  a_r6_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/gbf_gate.sv
module gbf_gate
  import gbf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fill_en,
  input  logic [1:0] arm_sel,
  input  logic       vdi,
  input  logic       sync_hit,
  input  logic       din_vld,
  output logic       wr_ok
);
  logic armed_q, armed_d, qual;

  always_comb begin
    unique case (arm_mode_e'(arm_sel))
      ARM_VALID:  qual = vdi;
      ARM_SYNC:   qual = sync_hit;
      ARM_EITHER: qual = vdi | sync_hit;
      ARM_BOTH:   qual = vdi & sync_hit;
      default:    qual = 1'b0;
    endcase
    armed_d = fill_en & (armed_q | qual);
    wr_ok   = din_vld & armed_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  // R11: disabling fill disarms the gate
  a_r11_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_en |=> !armed_q);
  // R4: armed state persists while enabled
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && fill_en) |=> armed_q);
endmodule

// File: rtl/gbf_store.sv
module gbf_store #(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr,
  input  logic             din,
  input  logic             pop,
  output logic [CNT_W-1:0] count,
  output logic             sdo,
  output logic             ovf_evt
);
  logic [DEPTH-1:0] mem_q;
  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sdo_q, sdo_d;
  logic             full, empty, do_pop, do_wr;

  always_comb begin
    full    = (cnt_q == CNT_W'(DEPTH));
    empty   = (cnt_q == '0);
    do_pop  = pop & ~empty & ~clr;
    do_wr   = wr & (~full | do_pop) & ~clr;
    ovf_evt = wr & full & ~do_pop & ~clr;
    sdo_d   = sdo_q;
    if (!clr && pop) sdo_d = empty ? 1'b0 : mem_q[rptr_q];
    if (clr) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      wptr_d = wptr_q + PTR_W'(do_wr);
      rptr_d = rptr_q + PTR_W'(do_pop);
      cnt_d  = cnt_q + CNT_W'(do_wr) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem_q[wptr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      sdo_q  <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
      sdo_q  <= sdo_d;
    end
  end

  assign count = cnt_q;
  assign sdo   = sdo_q;

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  a_r11_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);
  a_r8_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !wr && !clr) |=> (cnt_q == '0) && !sdo_q);
  a_r12_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && wr && !empty && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/gated_bit_fifo.sv
module gated_bit_fifo #(
  parameter int DEPTH       = 64,
  parameter int SYNC_STAGES = 2,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic             din_vld,
  input  logic             vdi,
  input  logic             sync_hit,
  input  logic             fill_en,
  input  logic [1:0]       arm_sel,
  input  logic [PTR_W-1:0] level,
  input  logic             sclk,
  input  logic             fsel_n,
  input  logic             stat_rd,
  output logic             sdo,
  output logic             fill_flag,
  output logic             stat_thr,
  output logic             stat_ovf
);
  logic [1:0]       rst_sh_q;
  logic             rst_s_n;
  logic             sel_n_s, sel_fall_unused, sclk_s_unused, sclk_fall;
  logic             wr_ok, pop, ovf_evt;
  logic [CNT_W-1:0] count;
  logic             flag_d_q, thr_q, thr_d, ovf_q, ovf_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_s_n = rst_sh_q[1];

  gbf_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sclk_sync (
    .clk(clk), .rst_n(rst_s_n), .d(sclk), .q(sclk_s_unused), .fall(sclk_fall));
  gbf_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sel_sync (
    .clk(clk), .rst_n(rst_s_n), .d(fsel_n), .q(sel_n_s), .fall(sel_fall_unused));

  gbf_gate u_gate (
    .clk(clk), .rst_n(rst_s_n), .fill_en(fill_en), .arm_sel(arm_sel),
    .vdi(vdi), .sync_hit(sync_hit), .din_vld(din_vld), .wr_ok(wr_ok));

  assign pop = sclk_fall & ~sel_n_s;

  gbf_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_s_n), .clr(~fill_en), .wr(wr_ok), .din(din),
    .pop(pop), .count(count), .sdo(sdo), .ovf_evt(ovf_evt));

  assign fill_flag = (count != '0) && (count >= CNT_W'(level));

  always_comb begin
    thr_d = (fill_flag & ~flag_d_q) | (thr_q & ~stat_rd);
    ovf_d = ovf_evt | (ovf_q & ~stat_rd);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      flag_d_q <= 1'b0;
      thr_q    <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      flag_d_q <= fill_flag;
      thr_q    <= thr_d;
      ovf_q    <= ovf_d;
    end
  end

  assign stat_thr = thr_q;
  assign stat_ovf = ovf_q;

  a_r10_thr_on_rise: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(fill_flag) |=> stat_thr);
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_s_n)
    (stat_ovf && !stat_rd) |=> stat_ovf);
  a_r7_no_pop_unselected: assert property (@(posedge clk) disable iff (!rst_s_n)
    (sel_n_s && !wr_ok && fill_en) |=> $stable(count) && $stable(sdo));
endmodule

// File: tb/gated_bit_fifo_tb_top.sv
module gated_bit_fifo_tb_top;
  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       din = 1'b0, din_vld = 1'b0, vdi = 1'b0, sync_hit = 1'b0;
  logic       fill_en = 1'b0, sclk = 1'b1, fsel_n = 1'b1, stat_rd = 1'b0;
  logic [1:0] arm_sel = 2'd0;
  logic [5:0] level = 6'd1;
  logic       sdo, fill_flag, stat_thr, stat_ovf;

  int    n_chk = 0, n_fail = 0, rd_delay = 0;
  string cur_req = "R1";
  bit    mq[$];
  bit    m_armed = 0, m_sdo = 0, m_thr = 0, m_ovf = 0, m_flag_d = 0;

  always #10 clk = ~clk;

  gated_bit_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .din(din), .din_vld(din_vld), .vdi(vdi),
    .sync_hit(sync_hit), .fill_en(fill_en), .arm_sel(arm_sel), .level(level),
    .sclk(sclk), .fsel_n(fsel_n), .stat_rd(stat_rd), .sdo(sdo),
    .fill_flag(fill_flag), .stat_thr(stat_thr), .stat_ovf(stat_ovf));

  function automatic bit exp_flag();
    return (mq.size() != 0) && (mq.size() >= int'(level));
  endfunction

  task automatic chk(input string what, input bit act, input bit exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit pop = 0, qual, allow, ovf_evt = 0, flag_now, thr_n;
    if (rd_delay > 0) begin
      rd_delay--;
      if (rd_delay == 0) pop = 1;
    end
    flag_now = exp_flag();
    thr_n = (flag_now && !m_flag_d) ? 1'b1 : (stat_rd ? 1'b0 : m_thr);
    m_flag_d = flag_now;
    if (!fill_en) begin
      mq.delete();
      m_armed = 0;
    end else begin
      case (arm_sel)
        2'd0: qual = vdi;
        2'd1: qual = sync_hit;
        2'd2: qual = vdi | sync_hit;
        default: qual = vdi & sync_hit;
      endcase
      allow = m_armed | qual;
      m_armed = allow;
      if (pop) m_sdo = (mq.size() > 0) ? mq.pop_front() : 1'b0;
      if (din_vld && allow) begin
        if (mq.size() < DEPTH) mq.push_back(din);
        else ovf_evt = 1;
      end
    end
    m_thr = thr_n;
    m_ovf = ovf_evt ? 1'b1 : (stat_rd ? 1'b0 : m_ovf);
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
    chk("fill_flag", fill_flag, exp_flag());
    chk("sdo", sdo, m_sdo);
    chk("stat_thr", stat_thr, m_thr);
    chk("stat_ovf", stat_ovf, m_ovf);
  endtask

  task automatic wr_bit(input bit b);
    din = b; din_vld = 1'b1; tick(); din_vld = 1'b0;
  endtask

  task automatic rd_bit(input bit also_wr, input bit wb);
    sclk = 1'b0; rd_delay = 3; tick(); tick();
    if (also_wr) begin din = wb; din_vld = 1'b1; end
    tick(); din_vld = 1'b0; tick();
    sclk = 1'b1; repeat (4) tick();
  endtask

  task automatic select(input bit on);
    fsel_n = ~on; repeat (3) tick();
  endtask

  task automatic clear_buf();
    fill_en = 1'b0; tick(); fill_en = 1'b1; vdi = 1'b0; sync_hit = 1'b0;
  endtask

  task automatic pulse_stat();
    stat_rd = 1'b1; tick(); stat_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cur_req = "R1";
    repeat (2) tick();
    rst_n = 1'b1;
    repeat (5) tick();
    chk("reset flag", fill_flag, 1'b0);
    chk("reset sdo", sdo, 1'b0);

    // R3 / R4: valid-data mode, pre-qualification bits discarded
    cur_req = "R3"; fill_en = 1'b1; arm_sel = 2'd0; level = 6'd1;
    wr_bit(1); wr_bit(1); wr_bit(0);
    chk("unarmed bits dropped", fill_flag, 1'b0);
    vdi = 1'b1; wr_bit(1); vdi = 1'b0;
    cur_req = "R4";
    wr_bit(0); wr_bit(1); wr_bit(1); wr_bit(0);
    chk("armed after vdi low", fill_flag, 1'b1);
    cur_req = "R6"; select(1);
    for (int i = 0; i < 5; i++) rd_bit(0, 0);
    chk("drained flag low", fill_flag, 1'b0);
    cur_req = "R8"; rd_bit(0, 0);
    chk("empty read sdo", sdo, 1'b0);
    select(0);

    cur_req = "R11"; clear_buf();
    wr_bit(1);
    chk("gate re-armed needed", fill_flag, 1'b0);

    cur_req = "R3"; arm_sel = 2'd1;
    vdi = 1'b1; wr_bit(1); vdi = 1'b0;
    chk("sync mode ignores vdi", fill_flag, 1'b0);
    sync_hit = 1'b1; wr_bit(1); sync_hit = 1'b0; wr_bit(0);
    chk("sync mode stored", fill_flag, 1'b1);
    clear_buf(); arm_sel = 2'd3;
    vdi = 1'b1; wr_bit(1); vdi = 1'b0;
    sync_hit = 1'b1; wr_bit(1); sync_hit = 1'b0;
    chk("both mode needs both", fill_flag, 1'b0);
    vdi = 1'b1; sync_hit = 1'b1; wr_bit(0); vdi = 1'b0; sync_hit = 1'b0;
    chk("both mode stored", fill_flag, 1'b1);
    clear_buf(); arm_sel = 2'd2;
    sync_hit = 1'b1; wr_bit(1); sync_hit = 1'b0;
    chk("either mode stored", fill_flag, 1'b1);
    clear_buf();

    cur_req = "R10"; pulse_stat(); tick();
    chk("thr cleared", stat_thr, 1'b0);
    cur_req = "R5"; arm_sel = 2'd0; level = 6'd3; vdi = 1'b1;
    wr_bit(1); wr_bit(0);
    chk("below level", fill_flag, 1'b0);
    wr_bit(1); vdi = 1'b0;
    chk("at level", fill_flag, 1'b1);
    tick();
    cur_req = "R10"; chk("thr set", stat_thr, 1'b1);
    pulse_stat(); chk("thr cleared by read", stat_thr, 1'b0);
    cur_req = "R5"; select(1); rd_bit(0, 0);
    chk("under level after read", fill_flag, 1'b0);
    select(0);

    cur_req = "R9"; clear_buf(); level = 6'd63; vdi = 1'b1;
    for (int i = 0; i < DEPTH + 2; i++) wr_bit(((i % 3) == 0) ^ i[3]);
    vdi = 1'b0;
    chk("ovf set", stat_ovf, 1'b1);
    tick(); chk("ovf sticky", stat_ovf, 1'b1);
    pulse_stat(); chk("ovf cleared", stat_ovf, 1'b0);
    cur_req = "R12"; select(1);
    rd_bit(1, 1);
    chk("full read+write no ovf", stat_ovf, 1'b0);
    cur_req = "R2";
    for (int i = 0; i < DEPTH; i++) rd_bit(0, 0);
    chk("drained", fill_flag, 1'b0);

    cur_req = "R12"; level = 6'd1; vdi = 1'b1;
    wr_bit(1); wr_bit(0); wr_bit(1);
    rd_bit(1, 0); rd_bit(1, 1);
    vdi = 1'b0;
    for (int i = 0; i < 3; i++) rd_bit(0, 0);
    chk("after simultaneous drain", fill_flag, 1'b0);
    select(0);

    cur_req = "R7"; vdi = 1'b1; wr_bit(1); wr_bit(0); vdi = 1'b0;
    sclk = 1'b0; repeat (4) tick(); sclk = 1'b1; repeat (4) tick();
    chk("unselected read ignored", fill_flag, 1'b1);
    select(1); rd_bit(0, 0);
    chk("oldest bit kept", sdo, 1'b1);
    rd_bit(0, 0);
    chk("second bit", sdo, 1'b0);
    select(0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule